// File: doc/BRIEF.md
# Clock-Detect Power-Up Sequencer

This controller keeps an audio converter datapath powered down until both its master clock and its frame (sample-rate) clock are seen toggling. It runs on a free-running reference clock. Both incoming clocks are brought into that domain through two-flop synchronisers and turned into rising-edge pulses. A per-clock timeout decides whether each clock is present.

Once both clocks are present, the controller counts master-clock edges across one whole frame and maps the count onto one of seven supported ratios. It then enables the voltage reference. After a programmable wait it enables the converter and output filter and releases the filter/modulator reset. It then waits out a programmable analog ramp period. Finally it lifts the audio mute after a programmable number of frames with valid sample data. With default settings that is about 2000 frames.

If either clock disappears, at any stage, the controller drops straight back to power-down. The ratio is measured again on every restart, and there is no minimum time spent powered down.

Top module: `clkdet_pwr_seq`

## Requirements
- R1: While reset is held and on leaving reset, the outputs are: mod_rst=1, vref_en=0, dac_en=0, unmute=0, ratio_err=0, ratio_code=0.
- R2: A clock counts as present once its synchronised rising edge has been seen. It stays present until MCLK_LOSS_CYC (master) or LRCK_LOSS_CYC (frame) reference cycles pass with no rising edge. The block stays powered down (mod_rst=1, vref_en=0) unless both clocks are present.
- R3: The ratio measurement waits for a frame-clock rising edge. It then counts master-clock rising edges up to the next frame-clock rising edge. A master edge that falls in the same cycle as a frame edge belongs to the new frame.
- R4: The count maps to ratio_code 0..6 for nominal ratios 128, 192, 256, 384, 512, 768 and 1152 respectively, when it lies within ±RATIO_TOL of the nominal value.
- R5: A count that matches no nominal value sets ratio_err=1 and returns the block to power-down, where it retries. vref_en stays 0 while ratio_err=1. A later good measurement clears ratio_err.
- R6: vref_en rises first, with mod_rst still 1. Exactly REF_WAIT_CYC reference cycles later, dac_en rises and mod_rst falls. dac_en is never 1 without vref_en.
- R7: After dac_en rises, the block waits RAMP_WAIT_CYC reference cycles before it starts counting valid frames. Unmute therefore comes no sooner than RAMP_WAIT_CYC + (UNMUTE_FRAMES-1) frames after dac_en.
- R8: Once the ramp is over, unmute rises on the UNMUTE_FRAMES-th frame-clock rising edge seen while data_valid stays high. data_valid low restarts the count. When data_valid goes low during playback, unmute falls one cycle later.
- R9: Losing either clock returns the block to power-down on the next cycle, from any stage. When both clocks come back, the ratio is measured afresh.
- R10: If a clock loss and the end of a stage wait occur in the same cycle, power-down takes precedence and the next stage is not entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_in | input | 1 | Master clock, asynchronous to clk |
| lrck_in | input | 1 | Frame clock, asynchronous to clk |
| data_valid | input | 1 | Sample data is valid |
| mod_rst | output | 1 | Reset for the interpolation filter and modulator (high = held) |
| vref_en | output | 1 | Voltage reference enable |
| dac_en | output | 1 | Converter and output-filter enable |
| ratio_code | output | 3 | Code of the last good ratio measurement |
| ratio_err | output | 1 | Last measurement was out of tolerance |
| unmute | output | 1 | Audio output unmuted |

## Verification
Two events can fall in the same cycle: the loss timeout of a clock and the end of the reference wait. The bench provokes this by restarting the master clock repeatedly and stopping it at a sweep of offsets after vref_en rises, so that the loss moves across the cycle where the wait ends. A behavioural model, compared on every reference cycle, judges the outcome. In the colliding cycle power-down must win, and dac_en must not rise.

// File: rtl/clkdet_pkg.sv
// Shared types and helpers for the clock-detect power-up sequencer.
// Assumes: the set of supported ratios is fixed at seven entries.
package clkdet_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_MEAS  = 3'd1,
        ST_REF   = 3'd2,
        ST_RAMP  = 3'd3,
        ST_MUTED = 3'd4,
        ST_PLAY  = 3'd5
    } seq_state_t;

    localparam int NUM_RATIOS = 7;
    localparam int RATIO_MAX  = 1152;

    typedef struct packed {
        logic       ok;
        logic [2:0] code;
    } ratio_res_t;

    // Nominal master clocks per frame for a ratio code.
    function automatic int unsigned ratio_nominal(input int idx);
        case (idx)
            0:       return 128;
            1:       return 192;
            2:       return 256;
            3:       return 384;
            4:       return 512;
            5:       return 768;
            default: return 1152;
        endcase
    endfunction

    // Map a measured count onto a ratio code within +/- tol.
    function automatic ratio_res_t classify_ratio(input int unsigned cnt,
                                                  input int unsigned tol);
        ratio_res_t res;
        int unsigned nom;
        res = '{ok: 1'b0, code: 3'd0};
        for (int i = 0; i < NUM_RATIOS; i++) begin
            nom = ratio_nominal(i);
            if (!res.ok && (cnt + tol >= nom) && (cnt <= nom + tol)) begin
                res.ok   = 1'b1;
                res.code = 3'(i);
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/sync_edge.sv
// Synchroniser and rising-edge detector for one asynchronous clock line.
// Assumes: the sampled line toggles no faster than half the reference rate.
module sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic rise
);
    localparam int TOP = STAGES;

    logic [TOP:0] sh;

    // Shift the raw level through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[TOP-1:0], raw_in};
    end

    // A rising edge is the newest synchronised 1 after a 0.
    assign rise = sh[TOP-1] & ~sh[TOP];

endmodule

// File: rtl/clk_watch.sv
// Presence monitor: a clock is present until LOSS_CYC cycles pass
// with no rising edge. Assumes: rise is already synchronised.
module clk_watch #(
    parameter int LOSS_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    output logic present
);
    localparam int CW = $clog2(LOSS_CYC + 1);

    logic [CW-1:0] age;

    // Count cycles since the last edge, saturating at the loss limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                        age <= CW'(LOSS_CYC);
        else if (rise)                     age <= '0;
        else if (age != CW'(LOSS_CYC))     age <= age + 1'b1;
    end

    assign present = (age != CW'(LOSS_CYC));

    // R2
    present_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> present);

endmodule

// File: rtl/ratio_meter.sv
// Counts master-clock edges across one frame while enabled and classifies
// the result. Assumes: both edge inputs come from matched synchronisers.
module ratio_meter
    import clkdet_pkg::*;
#(
    parameter int RATIO_TOL = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       meas_en,
    input  logic       m_rise,
    input  logic       l_rise,
    output logic       done,
    output logic       ok,
    output logic [2:0] code
);
    localparam int CNT_W = $clog2(RATIO_MAX + RATIO_TOL + 2) + 1;

    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] meas_q;
    ratio_res_t       res;

    // Arm on a frame edge, count master edges, latch the count on the next frame edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            cnt    <= '0;
            done   <= 1'b0;
            meas_q <= '0;
        end else if (!meas_en) begin
            armed <= 1'b0;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (l_rise) begin
                if (armed) begin
                    done   <= 1'b1;
                    meas_q <= cnt;
                end
                armed <= 1'b1;
                cnt   <= m_rise ? CNT_W'(1) : '0;
            end else if (armed && m_rise && (cnt != '1)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Classify the latched count.
    always_comb begin
        res  = classify_ratio(32'(meas_q), RATIO_TOL);
        ok   = res.ok;
        code = res.code;
    end

    // R3
    done_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(l_rise));

    // R3
    done_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_en |=> !done);

endmodule

// File: rtl/clkdet_pwr_seq.sv
// Top: detects both clocks, measures the ratio, steps the power enables,
// waits out the ramp and unmutes after enough valid frames.
// Assumes: clk runs faster than twice the master clock frequency.
module clkdet_pwr_seq
    import clkdet_pkg::*;
#(
    parameter int MCLK_LOSS_CYC = 64,
    parameter int LRCK_LOSS_CYC = 65536,
    parameter int REF_WAIT_CYC  = 1024,
    parameter int RAMP_WAIT_CYC = 12_500_000,
    parameter int UNMUTE_FRAMES = 2000,
    parameter int RATIO_TOL     = 4,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mclk_in,
    input  logic       lrck_in,
    input  logic       data_valid,
    output logic       mod_rst,
    output logic       vref_en,
    output logic       dac_en,
    output logic [2:0] ratio_code,
    output logic       ratio_err,
    output logic       unmute
);
    localparam int TMR_MAX = (RAMP_WAIT_CYC > REF_WAIT_CYC) ? RAMP_WAIT_CYC : REF_WAIT_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int FRM_W   = $clog2(UNMUTE_FRAMES + 1);

    logic [1:0] raw_vec;
    logic [1:0] rise_vec;
    logic [1:0] pres_vec;
    logic       clocks_ok;
    logic       m_done, m_ok;
    logic [2:0] m_code;

    seq_state_t       state;
    logic [TMR_W-1:0] tmr;
    logic [FRM_W-1:0] frm;
    logic [2:0]       code_q;
    logic             err_q;

    assign raw_vec = {lrck_in, mclk_in};

    // Channel 0 is the master clock, channel 1 the frame clock.
    for (genvar g = 0; g < 2; g++) begin : g_chan
        localparam int LOSS = (g == 0) ? MCLK_LOSS_CYC : LRCK_LOSS_CYC;
        sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_in (raw_vec[g]),
            .rise   (rise_vec[g])
        );
        clk_watch #(.LOSS_CYC(LOSS)) u_watch (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise    (rise_vec[g]),
            .present (pres_vec[g])
        );
    end

    assign clocks_ok = &pres_vec;

    ratio_meter #(.RATIO_TOL(RATIO_TOL)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .meas_en (state == ST_MEAS),
        .m_rise  (rise_vec[0]),
        .l_rise  (rise_vec[1]),
        .done    (m_done),
        .ok      (m_ok),
        .code    (m_code)
    );

    // Sequence state, stage timer, valid-frame counter and measurement result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_OFF;
            tmr    <= '0;
            frm    <= '0;
            code_q <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_OFF: begin
                    tmr <= '0;
                    frm <= '0;
                    if (clocks_ok) state <= ST_MEAS;
                end
                ST_MEAS: begin
                    if (!clocks_ok) begin
                        state <= ST_OFF;
                    end else if (m_done) begin
                        if (m_ok) begin
                            state  <= ST_REF;
                            code_q <= m_code;
                            err_q  <= 1'b0;
                            tmr    <= '0;
                        end else begin
                            state <= ST_OFF;
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_REF: begin
                    if (!clocks_ok) begin
                        state <= ST_OFF;
                    end else if (tmr == TMR_W'(REF_WAIT_CYC - 1)) begin
                        state <= ST_RAMP;
                        tmr   <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_RAMP: begin
                    if (!clocks_ok) begin
                        state <= ST_OFF;
                    end else if (tmr == TMR_W'(RAMP_WAIT_CYC - 1)) begin
                        state <= ST_MUTED;
                        frm   <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_MUTED: begin
                    if (!clocks_ok) begin
                        state <= ST_OFF;
                    end else if (!data_valid) begin
                        frm <= '0;
                    end else if (rise_vec[1]) begin
                        if (frm == FRM_W'(UNMUTE_FRAMES - 1)) state <= ST_PLAY;
                        else                                  frm   <= frm + 1'b1;
                    end
                end
                ST_PLAY: begin
                    if (!clocks_ok) begin
                        state <= ST_OFF;
                    end else if (!data_valid) begin
                        state <= ST_MUTED;
                        frm   <= '0;
                    end
                end
                default: state <= ST_OFF;
            endcase
        end
    end

    // Decode the power outputs from the sequence state.
    always_comb begin
        mod_rst = (state == ST_OFF) || (state == ST_MEAS) || (state == ST_REF);
        vref_en = (state == ST_REF) || (state == ST_RAMP) ||
                  (state == ST_MUTED) || (state == ST_PLAY);
        dac_en  = (state == ST_RAMP) || (state == ST_MUTED) || (state == ST_PLAY);
        unmute  = (state == ST_PLAY);
    end

    assign ratio_code = code_q;
    assign ratio_err  = err_q;

    // R6
    dac_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_en) |-> $past(vref_en));

    // R9
    loss_to_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF && !clocks_ok) |=> (state == ST_OFF));

    // R8
    mute_on_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unmute && !data_valid) |=> !unmute);

    // R5
    err_blocks_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_err |-> !vref_en);

endmodule

// File: tb/tb_clkdet_pwr_seq.sv
module tb_clkdet_pwr_seq;
    localparam int MLOSS = 8;
    localparam int LLOSS = 3000;
    localparam int REFW  = 20;
    localparam int RAMPW = 40;
    localparam int UNM   = 4;
    localparam int TOL   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclk_raw = 1'b0;
    logic lrck_raw = 1'b0;
    logic data_valid = 1'b0;
    logic mod_rst, vref_en, dac_en, ratio_err, unmute;
    logic [2:0] ratio_code;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int cyc = 0;

    // Stimulus controls
    bit mon = 0;
    bit lon = 0;
    int ratio = 256;
    int pc = 0;

    always #2.5 clk = ~clk;

    clkdet_pwr_seq #(
        .MCLK_LOSS_CYC(MLOSS), .LRCK_LOSS_CYC(LLOSS), .REF_WAIT_CYC(REFW),
        .RAMP_WAIT_CYC(RAMPW), .UNMUTE_FRAMES(UNM), .RATIO_TOL(TOL), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .mclk_in(mclk_raw), .lrck_in(lrck_raw),
        .data_valid(data_valid), .mod_rst(mod_rst), .vref_en(vref_en),
        .dac_en(dac_en), .ratio_code(ratio_code), .ratio_err(ratio_err), .unmute(unmute)
    );

    // Clock generators: master period two reference cycles, frame = ratio masters.
    always @(negedge clk) begin
        pc <= pc + 1;
        mclk_raw <= mon ? pc[0] : 1'b0;
        lrck_raw <= lon ? ((pc % (2 * ratio)) < ratio) : 1'b0;
    end

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int mh[3], lh[3];
    int mage, lage;
    int marm, mcnt, mdone, mres;
    int mst, mtmr, mfrm, merr, mcode;

    function automatic int bclass(input int c, output bit okv);
        int noms[7] = '{128, 192, 256, 384, 512, 768, 1152};
        okv = 0;
        for (int i = 0; i < 7; i++) begin
            if (c >= noms[i] - TOL && c <= noms[i] + TOL) begin
                okv = 1;
                return i;
            end
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        bit mr, lr, okc, cok;
        int so, cc;
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin mh[i] = 0; lh[i] = 0; end
            mage = MLOSS; lage = LLOSS;
            marm = 0; mcnt = 0; mdone = 0; mres = 0;
            mst = 0; mtmr = 0; mfrm = 0; merr = 0; mcode = 0;
        end else begin
            mr = (mh[1] == 1) && (mh[2] == 0);
            lr = (lh[1] == 1) && (lh[2] == 0);
            okc = (mage < MLOSS) && (lage < LLOSS);
            so = mst;
            if (mst != 0 && !okc) begin
                mst = 0;
            end else begin
                case (mst)
                    0: begin mtmr = 0; mfrm = 0; if (okc) mst = 1; end
                    1: if (mdone != 0) begin
                        cc = bclass(mres, cok);
                        if (cok) begin mst = 2; mcode = cc; merr = 0; mtmr = 0; end
                        else begin mst = 0; merr = 1; end
                    end
                    2: if (mtmr == REFW - 1) begin mst = 3; mtmr = 0; end else mtmr++;
                    3: if (mtmr == RAMPW - 1) begin mst = 4; mfrm = 0; end else mtmr++;
                    4: if (!data_valid) mfrm = 0;
                       else if (lr) begin
                           if (mfrm == UNM - 1) mst = 5; else mfrm++;
                       end
                    5: if (!data_valid) begin mst = 4; mfrm = 0; end
                    default: mst = 0;
                endcase
            end
            if (so != 1) begin
                marm = 0; mcnt = 0; mdone = 0;
            end else begin
                mdone = 0;
                if (lr) begin
                    if (marm != 0) begin mdone = 1; mres = mcnt; end
                    mcnt = mr ? 1 : 0;
                    marm = 1;
                end else if (marm != 0 && mr) mcnt++;
            end
            mage = mr ? 0 : (mage >= MLOSS ? MLOSS : mage + 1);
            lage = lr ? 0 : (lage >= LLOSS ? LLOSS : lage + 1);
            mh[2] = mh[1]; mh[1] = mh[0]; mh[0] = int'(mclk_raw);
            lh[2] = lh[1]; lh[1] = lh[0]; lh[0] = int'(lrck_raw);
        end
    end

    // Compare the design against the model on every cycle.
    always @(negedge clk) begin
        if (cyc > 0 && !finished) begin
            chk("R6", "mod_rst", int'(mod_rst), (mst <= 2) ? 1 : 0);
            chk("R6", "vref_en", int'(vref_en), (mst >= 2) ? 1 : 0);
            chk("R6", "dac_en", int'(dac_en), (mst >= 3) ? 1 : 0);
            chk("R8", "unmute", int'(unmute), (mst == 5) ? 1 : 0);
            chk("R4", "ratio_code", int'(ratio_code), mcode);
            chk("R5", "ratio_err", int'(ratio_err), merr);
        end
    end

    function automatic bit sig(input int which);
        case (which)
            0: return vref_en;
            1: return dac_en;
            default: return unmute;
        endcase
    endfunction

    task automatic wait_for(input int which, input bit level, input int limit, output int n);
        n = 0;
        while (sig(which) != level && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic restart(input int r);
        int n;
        lon = 0;
        wait_for(0, 1'b0, LLOSS + 20, n);
        ratio = r;
        lon = 1;
        wait_for(0, 1'b1, 4 * 2 * r + 100, n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R9 watchdog got running expected finished");
            finish_run();
        end
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1", "mod_rst", int'(mod_rst), 1);
        chk("R1", "vref_en", int'(vref_en), 0);
        chk("R1", "dac_en", int'(dac_en), 0);
        chk("R1", "unmute", int'(unmute), 0);
        chk("R1", "ratio_err", int'(ratio_err), 0);
        chk("R1", "ratio_code", int'(ratio_code), 0);
        rst_n = 1;
        repeat (100) @(negedge clk);
        chk("R2", "no clocks vref_en", int'(vref_en), 0);
        chk("R2", "no clocks mod_rst", int'(mod_rst), 1);
        mon = 1;
        repeat (3500) @(negedge clk);
        chk("R2", "master only vref_en", int'(vref_en), 0);
        ratio = 256;
        lon = 1;
        wait_for(0, 1'b1, 3000, n);
        chk("R3", "measured within two frames", (n <= 4 * 256 + 20) ? 1 : 0, 1);
        chk("R4", "code 256", int'(ratio_code), 2);
        chk("R6", "dac_en off at ref on", int'(dac_en), 0);
        chk("R6", "mod_rst held at ref on", int'(mod_rst), 1);
        wait_for(1, 1'b1, 200, n);
        chk("R6", "ref wait cycles", n, REFW);
        chk("R6", "mod_rst released", int'(mod_rst), 0);
        repeat (RAMPW + 5 * 512) @(negedge clk);
        chk("R8", "muted without valid", int'(unmute), 0);
        data_valid = 1;
        wait_for(2, 1'b1, 6 * 512, n);
        chk("R8", "unmute frame window", (n >= (UNM - 1) * 512 + 1 && n <= UNM * 512 + 4) ? 1 : 0, 1);
        data_valid = 0;
        @(negedge clk);
        chk("R8", "mute after invalid", int'(unmute), 0);
        data_valid = 1;
        wait_for(2, 1'b1, 6 * 512, n);
        chk("R8", "unmute again", int'(unmute), 1);
        // R9 master loss and re-measure at a new ratio
        mon = 0;
        wait_for(0, 1'b0, 100, n);
        chk("R9", "master loss latency", (n <= MLOSS + 6) ? 1 : 0, 1);
        chk("R9", "mod_rst after loss", int'(mod_rst), 1);
        ratio = 512;
        mon = 1;
        wait_for(0, 1'b1, 5000, n);
        chk("R9", "re-measured code 512", int'(ratio_code), 4);
        wait_for(1, 1'b1, 200, n);
        wait_for(2, 1'b1, 8 * 1024, n);
        chk("R7", "ramp before unmute", (n >= RAMPW + (UNM - 1) * 1024) ? 1 : 0, 1);
        chk("R8", "unmute upper bound", (n <= RAMPW + UNM * 1024 + 4) ? 1 : 0, 1);
        // R9 frame loss
        lon = 0;
        wait_for(0, 1'b0, LLOSS + 50, n);
        chk("R9", "frame loss latency", (n <= LLOSS + 6) ? 1 : 0, 1);
        // R5 out of tolerance, then boundary in tolerance
        ratio = 259;
        lon = 1;
        repeat (5 * 518) @(negedge clk);
        chk("R5", "error flag 259", int'(ratio_err), 1);
        chk("R5", "vref held off", int'(vref_en), 0);
        ratio = 258;
        wait_for(0, 1'b1, 3000, n);
        chk("R5", "error cleared", int'(ratio_err), 0);
        chk("R4", "code 258 in tolerance", int'(ratio_code), 2);
        restart(1152);
        chk("R4", "code 1152", int'(ratio_code), 6);
        restart(190);
        chk("R4", "code 190", int'(ratio_code), 1);
        restart(128);
        // R10 sweep loss across the end of the reference wait
        for (int k = 0; k < 15; k++) begin
            if (!vref_en) begin
                mon = 1;
                wait_for(0, 1'b1, 2000, n);
            end
            repeat (k) @(negedge clk);
            mon = 0;
            wait_for(0, 1'b0, MLOSS + 40, n);
            chk("R10", "powered down after loss", int'(vref_en), 0);
            chk("R10", "dac off after loss", int'(dac_en), 0);
            mon = 1;
            wait_for(0, 1'b1, 2000, n);
        end
        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule